// File: doc/BRIEF.md
# Dual-Channel Sample Output Formatter

This block takes one pair of 10-bit conversion results per sample period, one word for channel I and one for channel Q, and presents them on two 10-bit output buses. A coding input chooses plain offset-binary or two's-complement output. A layout input chooses one of two modes. In dual-bus mode each channel has its own bus. In shared-bus mode the two words take turns on the I bus, the Q bus stays at zero, and a channel flag tells the receiver which word is on the bus.

The block runs on a clock at twice the sample rate. The sample clock is given as `smp_tick`, a strobe that is high on every other fast edge and phase-locked to it. Each fast-clock edge where `smp_tick` is high is a sample boundary. Inputs, coding choice and layout choice are captured only at these edges. The first half of each output sample period carries I data and the second half carries Q data. Latencies are stated below in fast-clock cycles, counted from the capturing edge. One sample period is two fast cycles.

Top module: `adc_iq_formatter`

## Requirements
- R1: With `fmt_twos` low at the capturing edge, each output word equals the raw input code unchanged (bit 0 LSB, bit 9 MSB).
- R2: With `fmt_twos` high at the capturing edge, each output word equals the raw code with bit 9 inverted. Raw 512 gives 0, raw 0 gives 512, raw 1023 gives 511 and raw 511 gives 1023.
- R3: With `bus_par` high at the capturing edge, `bus_i` carries the I word and `bus_q` carries the Q word of the same sample. Both hold for two fast cycles.
- R4: With `bus_par` low at the capturing edge, `bus_i` carries the I word for one fast cycle and then the Q word for one fast cycle. `bus_q` is zero throughout.
- R5: In shared-bus mode `chan_flag` is 1 while the I word is on `bus_i` and 0 while the Q word is on it.
- R6: In dual-bus mode `chan_flag` is 1 in the first fast cycle of each output sample and 0 in the second, so it rises once for each new pair of words.
- R7: A sample captured at edge E appears on the outputs after edge E+5 in dual-bus mode and for the I word in shared-bus mode. The Q word in shared-bus mode appears after edge E+6.
- R8: Inputs, `fmt_twos` and `bus_par` are sampled only at edges where `smp_tick` is high. Changes between those edges have no effect, so a mode or coding change applies to whole samples.
- R9: After reset both buses and `chan_flag` stay 0 until the first captured sample reaches the outputs.
- R10: `smp_tick` alternates high and low on successive fast-clock edges while reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Fast clock at twice the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_tick | input | 1 | Sample-boundary strobe, high on alternate fast edges |
| fmt_twos | input | 1 | 1 = two's-complement coding, 0 = offset binary |
| bus_par | input | 1 | 1 = dual-bus layout, 0 = shared-bus layout |
| ch_i_raw | input | 10 | Raw conversion code for channel I |
| ch_q_raw | input | 10 | Raw conversion code for channel Q |
| bus_i | output | 10 | Output bus I |
| bus_q | output | 10 | Output bus Q |
| chan_flag | output | 1 | Channel / new-data flag |

## Verification
The stimulus switches layout and coding on every few samples and drives garbage inputs and inverted mode pins on the off-tick cycles. A design that sampled away from the sample boundary would then put garbage words or the wrong coding on the bus. Corner codes 0, 511, 512 and 1023 are sent in both codings, so an inverted sign bit or a full negation instead of an MSB flip shows up as a wrong word. The scoreboard expects one item per fast cycle, starting exactly five cycles after the first capture. If the Q word arrived with I latency, or the I and Q halves were swapped, the order check would fail. A Q bus left driven in shared-bus mode would also fail it. Outputs are checked at zero during pipeline fill, which catches a design that lets stale register contents out before the first sample arrives.

// File: rtl/adc_iq_pkg.sv
package adc_iq_pkg;
    localparam int SMP_W = 10;

    typedef logic [SMP_W-1:0] word_t;

    typedef struct packed {
        logic  vld;
        logic  par;
        word_t i;
        word_t q;
    } smp_t;

    typedef struct packed {
        word_t bus_i;
        word_t bus_q;
        logic  chan;
    } out_t;
endpackage

// File: rtl/adc_iq_code.sv
module adc_iq_code #(
    parameter int W = 10
) (
    input  logic [W-1:0] raw,
    input  logic         twos,
    output logic [W-1:0] coded
);
    // offset binary to two's complement: flip the sign position only
    always_comb begin
        coded        = raw;
        coded[W-1]   = raw[W-1] ^ twos;
    end
endmodule

// File: rtl/adc_iq_pipe.sv
module adc_iq_pipe
    import adc_iq_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic  clk2x,
    input  logic  rst_n,
    input  logic  smp_tick,
    input  word_t i_code,
    input  word_t q_code,
    input  logic  par_sel,
    output smp_t  tail
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        smp_t [STAGES-1:0] stg;
    } pipe_state_t;

    pipe_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (smp_tick) begin
            st_d.stg[0].vld = 1'b1;
            st_d.stg[0].par = par_sel;
            st_d.stg[0].i   = i_code;
            st_d.stg[0].q   = q_code;
            for (int k = 1; k < STAGES; k++) begin
                st_d.stg[k] = st_q.stg[k-1];
            end
        end
    end

    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tail = st_q.stg[LAST];

    // R10: the sample strobe must alternate
    a_r10_tick_falls: assert property (@(posedge clk2x) disable iff (!rst_n)
        smp_tick |=> !smp_tick);
    a_r10_tick_rises: assert property (@(posedge clk2x) disable iff (!rst_n)
        !smp_tick |=> smp_tick);
    // R8: nothing is captured between sample boundaries
    a_r8_hold_off_tick: assert property (@(posedge clk2x) disable iff (!rst_n)
        !smp_tick |=> $stable(st_q.stg[0]));
endmodule

// File: rtl/adc_iq_outmux.sv
module adc_iq_outmux
    import adc_iq_pkg::*;
(
    input  logic  clk2x,
    input  logic  rst_n,
    input  logic  smp_tick,
    input  smp_t  tail,
    output word_t bus_i,
    output word_t bus_q,
    output logic  chan
);
    out_t out_d, out_q;

    always_comb begin
        out_d = '0;
        if (tail.vld) begin
            if (!smp_tick) begin
                // first half of the output sample: I word, flag high
                out_d.bus_i = tail.i;
                out_d.bus_q = tail.par ? tail.q : '0;
                out_d.chan  = 1'b1;
            end else begin
                // second half: keep pair (dual bus) or present Q (shared bus)
                out_d.bus_i = tail.par ? tail.i : tail.q;
                out_d.bus_q = tail.par ? tail.q : '0;
                out_d.chan  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign bus_i = out_q.bus_i;
    assign bus_q = out_q.bus_q;
    assign chan  = out_q.chan;

    // R9: quiet outputs until a sample reaches the end of the pipe
    a_r9_idle_zero: assert property (@(posedge clk2x) disable iff (!rst_n)
        !tail.vld |=> (bus_i == '0 && bus_q == '0 && !chan));
    // R5 / R6: flag high in the first half, low in the second
    a_r5_flag_first: assert property (@(posedge clk2x) disable iff (!rst_n)
        (!smp_tick && tail.vld) |=> chan);
    a_r6_flag_second: assert property (@(posedge clk2x) disable iff (!rst_n)
        smp_tick |=> !chan);
    // R4: Q bus silent in shared-bus layout
    a_r4_q_quiet: assert property (@(posedge clk2x) disable iff (!rst_n)
        (tail.vld && !tail.par) |=> bus_q == '0);
    // R3: dual-bus words held across both halves
    a_r3_pair_held: assert property (@(posedge clk2x) disable iff (!rst_n)
        (smp_tick && tail.vld && tail.par) |=> ($stable(bus_i) && $stable(bus_q)));
endmodule

// File: rtl/adc_iq_formatter.sv
module adc_iq_formatter
    import adc_iq_pkg::*;
#(
    parameter int PIPE_STAGES = 3
) (
    input  logic             clk2x,
    input  logic             rst_n,
    input  logic             smp_tick,
    input  logic             fmt_twos,
    input  logic             bus_par,
    input  logic [SMP_W-1:0] ch_i_raw,
    input  logic [SMP_W-1:0] ch_q_raw,
    output logic [SMP_W-1:0] bus_i,
    output logic [SMP_W-1:0] bus_q,
    output logic             chan_flag
);
    localparam int NCH = 2;

    word_t raw_w  [NCH];
    word_t code_w [NCH];
    smp_t  tail_w;

    assign raw_w[0] = ch_i_raw;
    assign raw_w[1] = ch_q_raw;

    for (genvar c = 0; c < NCH; c++) begin : g_code
        adc_iq_code #(.W(SMP_W)) i_code (
            .raw   (raw_w[c]),
            .twos  (fmt_twos),
            .coded (code_w[c])
        );
    end

    adc_iq_pipe #(.STAGES(PIPE_STAGES)) i_pipe (
        .clk2x    (clk2x),
        .rst_n    (rst_n),
        .smp_tick (smp_tick),
        .i_code   (code_w[0]),
        .q_code   (code_w[1]),
        .par_sel  (bus_par),
        .tail     (tail_w)
    );

    adc_iq_outmux i_outmux (
        .clk2x    (clk2x),
        .rst_n    (rst_n),
        .smp_tick (smp_tick),
        .tail     (tail_w),
        .bus_i    (bus_i),
        .bus_q    (bus_q),
        .chan     (chan_flag)
    );
endmodule

// File: tb/test_adc_iq_formatter.sv
`timescale 1ns/1ps
module test_adc_iq_formatter;
    logic       clk2x = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_tick = 1'b0;
    logic       fmt_twos = 1'b0;
    logic       bus_par = 1'b0;
    logic [9:0] ch_i_raw = '0;
    logic [9:0] ch_q_raw = '0;
    logic [9:0] bus_i, bus_q;
    logic       chan_flag;

    always #2 clk2x = ~clk2x;   // 250 MHz

    adc_iq_formatter i_adc_iq_formatter (
        .clk2x(clk2x), .rst_n(rst_n), .smp_tick(smp_tick),
        .fmt_twos(fmt_twos), .bus_par(bus_par),
        .ch_i_raw(ch_i_raw), .ch_q_raw(ch_q_raw),
        .bus_i(bus_i), .bus_q(bus_q), .chan_flag(chan_flag)
    );

    typedef struct {
        logic [9:0] ei;
        logic [9:0] eq;
        logic       ef;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   started = 0;
    bit   done = 0;
    int   edges = 0;

    function automatic logic [9:0] code(input logic [9:0] r, input logic t);
        return t ? (r ^ 10'h200) : r;
    endfunction

    task automatic send(input logic [9:0] iv, input logic [9:0] qv,
                        input logic t, input logic p);
        exp_t a, b;
        logic [9:0] ci, cq;
        string base;
        @(negedge clk2x);
        smp_tick = 1'b1;
        ch_i_raw = iv; ch_q_raw = qv; fmt_twos = t; bus_par = p;
        started  = 1'b1;
        ci = code(iv, t); cq = code(qv, t);
        base = t ? "R2" : "R1";
        if (p) begin
            a = '{ci, cq, 1'b1, {base, " R3 R6 R7 R8"}};
            b = '{ci, cq, 1'b0, {base, " R3 R6 R8"}};
        end else begin
            a = '{ci, 10'd0, 1'b1, {base, " R4 R5 R7 R8"}};
            b = '{cq, 10'd0, 1'b0, {base, " R4 R5 R7 R8"}};
        end
        exp_q.push_back(a);
        exp_q.push_back(b);
        @(negedge clk2x);
        // off-boundary garbage: must not be captured (R8)
        smp_tick = 1'b0;
        ch_i_raw = ~iv; ch_q_raw = ~qv; fmt_twos = ~t; bus_par = ~p;
    endtask

    always @(posedge clk2x) if (started) edges <= edges + 1;

    always @(negedge clk2x) begin
        if (started && edges >= 1 && edges <= 5) begin
            n_chk++;
            if (bus_i != 0 || bus_q != 0 || chan_flag != 0) begin
                n_bad++;
                $display("FAIL R9 fill: got %h/%h/%b expected 000/000/0",
                         bus_i, bus_q, chan_flag);
            end
        end else if (edges >= 6 && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (bus_i != e.ei || bus_q != e.eq || chan_flag != e.ef) begin
                n_bad++;
                $display("FAIL %s: got %h/%h/%b expected %h/%h/%b",
                         e.tag, bus_i, bus_q, chan_flag, e.ei, e.eq, e.ef);
            end
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            @(negedge clk2x) smp_tick = 1'b1;
            @(negedge clk2x) smp_tick = 1'b0;
        end
        rst_n = 1'b1;
        // corner codes in both codings and layouts
        send(10'd0,    10'd1023, 1'b0, 1'b1);
        send(10'd512,  10'd511,  1'b1, 1'b1);
        send(10'd0,    10'd1023, 1'b1, 1'b0);
        send(10'd512,  10'd511,  1'b0, 1'b0);
        send(10'd511,  10'd512,  1'b1, 1'b0);
        send(10'd1023, 10'd0,    1'b1, 1'b1);
        for (int k = 0; k < 40; k++) begin
            send(10'((k * 97 + 3) % 1024), 10'((k * 211 + 77) % 1024),
                 1'(k[0] ^ k[2]), 1'(k[1] ^ k[3]));
        end
        // keep the strobe running while the scoreboard drains
        while (exp_q.size() > 0) begin
            @(negedge clk2x) smp_tick = 1'b1;
            @(negedge clk2x) smp_tick = 1'b0;
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk2x);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule